// File: doc/BRIEF.md
# Synchronous SRAM Read Output Path with Selectable Deselect Timing

This block is the read-data side of a synchronous burst SRAM. Commands (chip select, write flag, address, write data) are captured on the rising clock edge into an input stage. A read fetches a word from a small parameterized register array and sends it towards a pad driver pair: a data word and a drive enable that an I/O cell turns into a three-state bus.

Two static mode pins shape the timing. `reg_out_mode` chooses between a flow-through path, where the array word leaves straight from the input stage, and a registered path, where one extra clocked data stage adds a cycle of latency. `late_release` chooses how long the bus stays driven after the last read. With it low, the drive drops as soon as a non-read command reaches the final stage. With it high, the drive and the last word are held for one further cycle. A write ends the drive at the same point as a deselect. The asynchronous output enable gates the drive without waiting for a clock edge. The mode pins may only change while the path is idle.

Top module: `sro_read_out`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `dq_drive` is 0.
- R2: With `reg_out_mode`=0, a read captured at edge k makes `dq_drive`=1 and `dq_out` equal to the stored word at its address in the cycle after edge k, if `out_en`=1.
- R3: With `reg_out_mode`=1, a read captured at edge k leaves `dq_drive` unchanged by it after edge k. Its word and `dq_drive`=1 appear in the cycle after edge k+1.
- R4: With `late_release`=0, `dq_drive` is 0 in any cycle whose final stage holds no read. The final stage is the input stage when `reg_out_mode`=0 and the extra data stage when it is 1.
- R5: With `late_release`=1, the drive stays on for exactly one cycle after the final stage stops holding a read, with `dq_out` unchanged from the last read word. It then drops to 0.
- R6: `out_en`=0 forces `dq_drive` to 0 at once, independent of the clock. Setting it back to 1 restores the drive within the same cycle.
- R7: A captured write (`chip_en`=1, `wr_en`=1) stores `wdata` at `addr`. It ends the drive like a deselect. A read captured on the next edge returns the new word.
- R8: Reads on consecutive edges give one word per cycle in command order, with `dq_drive` held at 1 throughout.
- R9: With `chip_en`=0, `wr_en` and `wdata` have no effect on the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the pipeline state |
| reg_out_mode | input | 1 | 0: flow-through output, 1: registered output (static) |
| late_release | input | 1 | 0: release the bus at once, 1: hold it one extra cycle (static) |
| chip_en | input | 1 | Command select; 0 is a deselect |
| wr_en | input | 1 | With chip_en=1: 1 write, 0 read |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data, sampled with a write command |
| out_en | input | 1 | Asynchronous output enable, active high |
| dq_out | output | DATA_W | Word presented to the pad driver |
| dq_drive | output | 1 | Pad drive enable; 0 means high impedance |

## Verification
The bench aims at the release edge in all four mode pairings. A design that mixed up the two release settings would either cut off the last word of a registered read or keep the bus driven into the following write. The registered path is probed in the cycle right after a read is captured, where a missing data stage would drive one cycle early. The write-after-read case checks both that the held word is the old contents and that the next read returns the new one. Mid-cycle output-enable toggles expose any design that samples the enable on the clock.

// File: rtl/sro_pkg.sv
package sro_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_e;

  // Turn the sampled select and write flag into a command.
  function automatic cmd_e decode_cmd(input logic ce, input logic we);
    if (!ce) return CMD_IDLE;
    if (we)  return CMD_WRITE;
    return CMD_READ;
  endfunction

  // Drive token: the final stage holds a read, or (late release) held one
  // on the previous cycle.
  function automatic logic drive_token(input logic final_rd,
                                       input logic prev_final_rd,
                                       input logic late);
    return final_rd | (late & prev_final_rd);
  endfunction

  // Word presented at the output: fresh array word in flow-through when the
  // input stage reads, otherwise the held word.
  function automatic logic [63:0] pick_word(input logic reg_mode,
                                            input logic s1_rd,
                                            input logic [63:0] fresh,
                                            input logic [63:0] held);
    return (!reg_mode && s1_rd) ? fresh : held;
  endfunction

endpackage

// File: rtl/sro_cmd_stage.sv
module sro_cmd_stage
  import sro_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_now,
  output logic              s1_read,
  output logic [ADDR_W-1:0] s1_addr
);

  cmd_e in_cmd;

  always_comb begin
    in_cmd = decode_cmd(chip_en, wr_en);
    wr_now = (in_cmd == CMD_WRITE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_read <= 1'b0;
      s1_addr <= '0;
    end else begin
      s1_read <= (in_cmd == CMD_READ);
      s1_addr <= addr;
    end
  end

endmodule

// File: rtl/sro_array.sv
module sro_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              wr_now,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_now) mem[wr_addr] <= wdata;
  end

  assign rd_word = mem[rd_addr];

endmodule

// File: rtl/sro_out_path.sv
module sro_out_path
  import sro_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_out_mode,
  input  logic              s1_read,
  input  logic [DATA_W-1:0] rd_word,
  output logic              final_rd,
  output logic [DATA_W-1:0] final_data
);

  logic              s2_read;
  logic [DATA_W-1:0] held_word;
  logic [63:0]       fresh_w, held_w, pick_w;

  // Extra data stage: loads only when the input stage reads, so it also
  // serves as the hold register for the flow-through path.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_read   <= 1'b0;
      held_word <= '0;
    end else begin
      s2_read <= s1_read;
      if (s1_read) held_word <= rd_word;
    end
  end

  always_comb begin
    fresh_w    = 64'(rd_word);
    held_w     = 64'(held_word);
    pick_w     = pick_word(reg_out_mode, s1_read, fresh_w, held_w);
    final_data = pick_w[DATA_W-1:0];
    final_rd   = reg_out_mode ? s2_read : s1_read;
  end

endmodule

// File: rtl/sro_drive_ctl.sv
module sro_drive_ctl
  import sro_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic late_release,
  input  logic final_rd,
  input  logic out_en,
  output logic drive_tok,
  output logic dq_drive
);

  logic prev_final_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_final_rd <= 1'b0;
    else        prev_final_rd <= final_rd;
  end

  always_comb begin
    drive_tok = drive_token(final_rd, prev_final_rd, late_release);
    dq_drive  = drive_tok & out_en;
  end

endmodule

// File: rtl/sro_read_out.sv
module sro_read_out
  import sro_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_out_mode,
  input  logic              late_release,
  input  logic              chip_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              out_en,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_drive
);

  logic              wr_now;
  logic              s1_read;
  logic [ADDR_W-1:0] s1_addr;
  logic [DATA_W-1:0] rd_word;
  logic              final_rd;
  logic [DATA_W-1:0] final_data;
  logic              drive_tok;

  sro_cmd_stage #(.ADDR_W(ADDR_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .wr_en(wr_en),
    .addr(addr), .wr_now(wr_now), .s1_read(s1_read), .s1_addr(s1_addr)
  );

  sro_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .wr_now(wr_now), .wr_addr(addr), .wdata(wdata),
    .rd_addr(s1_addr), .rd_word(rd_word)
  );

  sro_out_path #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .reg_out_mode(reg_out_mode),
    .s1_read(s1_read), .rd_word(rd_word),
    .final_rd(final_rd), .final_data(final_data)
  );

  sro_drive_ctl u_drv (
    .clk(clk), .rst_n(rst_n), .late_release(late_release),
    .final_rd(final_rd), .out_en(out_en),
    .drive_tok(drive_tok), .dq_drive(dq_drive)
  );

  assign dq_out = final_data;

endmodule

// File: rtl/sro_read_out_chk.sv
module sro_read_out_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_out_mode,
  input logic              late_release,
  input logic              chip_en,
  input logic              wr_en,
  input logic              out_en,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_drive
);

  logic is_rd;
  assign is_rd = chip_en & ~wr_en;

  // R6
  oe_gates_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_drive |-> out_en);

  // R2
  flow_read_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_out_mode && out_en && $past(rst_n) && $past(is_rd)) |-> dq_drive);

  // R3
  reg_read_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_out_mode && out_en && $past(rst_n) && $past(rst_n, 2) && $past(is_rd, 2))
      |-> dq_drive);

  // R4
  flow_fast_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_out_mode && !late_release && !$past(is_rd)) |-> !dq_drive);

  // R4
  reg_fast_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_out_mode && !late_release && !$past(is_rd, 2)) |-> !dq_drive);

  // R5
  flow_late_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_out_mode && late_release && !$past(is_rd) && !$past(is_rd, 2))
      |-> !dq_drive);

  // R5
  flow_late_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_out_mode && late_release && $past(rst_n, 2) && !$past(is_rd)
     && $past(is_rd, 2)) |-> $stable(dq_out));

endmodule

bind sro_read_out sro_read_out_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_out_mode(reg_out_mode),
  .late_release(late_release), .chip_en(chip_en), .wr_en(wr_en),
  .out_en(out_en), .dq_out(dq_out), .dq_drive(dq_drive)
);

// File: tb/tb_sro_read_out.sv
module tb_sro_read_out;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, reg_out_mode, late_release, chip_en, wr_en, out_en;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, dq_out;
  logic          dq_drive;

  sro_read_out #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_out_mode(reg_out_mode),
    .late_release(late_release), .chip_en(chip_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .out_en(out_en),
    .dq_out(dq_out), .dq_drive(dq_drive)
  );

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] shadow [NW];

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(16'hC3A0 ^ (a * 16'h0111));
  endfunction

  task automatic chk_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: dq_drive actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic chk_word(input string req, input logic [DW-1:0] act,
                          input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: dq_out actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One command per clock; outputs are settled 1 ns after the edge.
  task automatic step(input logic ce, input logic we, input logic [AW-1:0] a,
                      input logic [DW-1:0] d);
    @(negedge clk);
    chip_en = ce; wr_en = we; addr = a; wdata = d;
    @(posedge clk);
    if (ce && we) shadow[a] = d;
    #1;
  endtask

  task automatic idle(); step(1'b0, 1'b0, '0, '0); endtask

  task automatic set_mode(input logic rm, input logic late);
    idle(); idle(); idle();
    @(negedge clk);
    reg_out_mode = rm; late_release = late;
    idle();
  endtask

  task automatic t_reset();
    chk_bit("R1 in reset", dq_drive, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk_bit("R1 after release", dq_drive, 1'b0);
  endtask

  task automatic t_preload();
    for (int a = 0; a < NW; a++) step(1'b1, 1'b1, AW'(a), pat(a));
  endtask

  task automatic t_flow_fast();
    set_mode(1'b0, 1'b0);
    step(1'b1, 1'b0, 4'd3, '0);
    chk_bit("R2 flow drive", dq_drive, 1'b1);
    chk_word("R2 flow data", dq_out, shadow[3]);
    idle();
    chk_bit("R4 flow release", dq_drive, 1'b0);
  endtask

  task automatic t_flow_late();
    set_mode(1'b0, 1'b1);
    step(1'b1, 1'b0, 4'd5, '0);
    chk_word("R2 flow late data", dq_out, shadow[5]);
    idle();
    chk_bit("R5 flow hold drive", dq_drive, 1'b1);
    chk_word("R5 flow hold data", dq_out, shadow[5]);
    idle();
    chk_bit("R5 flow release", dq_drive, 1'b0);
  endtask

  task automatic t_reg_fast();
    set_mode(1'b1, 1'b0);
    step(1'b1, 1'b0, 4'd7, '0);
    chk_bit("R3 no early drive", dq_drive, 1'b0);
    idle();
    chk_bit("R3 reg drive", dq_drive, 1'b1);
    chk_word("R3 reg data", dq_out, shadow[7]);
    idle();
    chk_bit("R4 reg release", dq_drive, 1'b0);
  endtask

  task automatic t_reg_late();
    set_mode(1'b1, 1'b1);
    step(1'b1, 1'b0, 4'd9, '0);
    chk_bit("R3 late no early drive", dq_drive, 1'b0);
    idle();
    chk_word("R3 late reg data", dq_out, shadow[9]);
    idle();
    chk_bit("R5 reg hold drive", dq_drive, 1'b1);
    chk_word("R5 reg hold data", dq_out, shadow[9]);
    idle();
    chk_bit("R5 reg release", dq_drive, 1'b0);
  endtask

  task automatic t_burst();
    set_mode(1'b1, 1'b0);
    step(1'b1, 1'b0, 4'd1, '0);
    step(1'b1, 1'b0, 4'd2, '0);
    chk_bit("R8 burst drive 1", dq_drive, 1'b1);
    chk_word("R8 burst word 1", dq_out, shadow[1]);
    step(1'b1, 1'b0, 4'd3, '0);
    chk_bit("R8 burst drive 2", dq_drive, 1'b1);
    chk_word("R8 burst word 2", dq_out, shadow[2]);
    idle();
    chk_bit("R8 burst drive 3", dq_drive, 1'b1);
    chk_word("R8 burst word 3", dq_out, shadow[3]);
    idle();
    chk_bit("R8 burst end", dq_drive, 1'b0);
  endtask

  task automatic t_oe();
    set_mode(1'b0, 1'b0);
    step(1'b1, 1'b0, 4'd4, '0);
    chk_bit("R6 enabled", dq_drive, 1'b1);
    out_en = 1'b0; #2;
    chk_bit("R6 async off", dq_drive, 1'b0);
    out_en = 1'b1; #1;
    chk_bit("R6 async on", dq_drive, 1'b1);
    chk_word("R6 data kept", dq_out, shadow[4]);
    idle();
  endtask

  task automatic t_write();
    logic [DW-1:0] old;
    set_mode(1'b0, 1'b1);
    old = shadow[6];
    step(1'b1, 1'b0, 4'd6, '0);
    step(1'b1, 1'b1, 4'd6, 16'h5EED);
    chk_bit("R7 write holds like deselect", dq_drive, 1'b1);
    chk_word("R7 held word is old", dq_out, old);
    step(1'b1, 1'b0, 4'd6, '0);
    chk_word("R7 read after write", dq_out, 16'h5EED);
    step(1'b1, 1'b1, 4'd8, 16'h0F0F);
    step(1'b1, 1'b1, 4'd8, 16'h1234);
    chk_bit("R7 writes release drive", dq_drive, 1'b0);
    idle();
  endtask

  task automatic t_ignore();
    set_mode(1'b0, 1'b0);
    step(1'b0, 1'b1, 4'd2, 16'hDEAD);
    step(1'b1, 1'b0, 4'd2, '0);
    chk_word("R9 deselected write ignored", dq_out, pat(2));
    idle();
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_out_mode = 1'b0; late_release = 1'b0;
    chip_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; out_en = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_preload();
    t_flow_fast();
    t_flow_late();
    t_reg_fast();
    t_reg_late();
    t_burst();
    t_oe();
    t_write();
    t_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule